// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat synchronous burst into a memory. A start strobe captures a full external address. Each later cycle with the advance input high steps the two lowest address bits to the next beat. The upper address bits stay fixed, so every burst wraps inside the aligned four-word block that holds its starting word.

The counting order is selected at load time. Linear order adds the beat number to the starting low bits. Interleaved order XORs the beat number with them. There are two start strobes, one meant for a processor and one for a memory controller, and either one loads the address. A new address can be loaded on every cycle, so a system that does not burst can use the block as a plain registered address path.

All inputs are sampled on the rising edge of a single clock. The outputs come straight from registers, apart from a small adder or XOR stage on the two low bits.

Top module: `bas_burst_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block resets: `addr_out` becomes 0, `beat` becomes 0 and the captured order becomes interleaved.
- R2: When `start_cpu` or `start_ctl` (or both) is high at a rising edge, `addr_out` equals the `addr_in` sampled at that edge and `beat` equals 0 after that edge.
- R3: When neither strobe is high and `adv` is high at a rising edge, `beat` increases by one modulo 4 (3 is followed by 0).
- R4: When neither strobe nor `adv` is high at a rising edge, `addr_out` and `beat` keep their values.
- R5: With linear order captured (`lin_mode` = 1 at load), `addr_out[1:0]` equals (start low bits + `beat`) mod 4. For a start of 2 this gives 2, 3, 0, 1.
- R6: With interleaved order captured (`lin_mode` = 0 at load), `addr_out[1:0]` equals the start low bits XOR `beat`. For a start of 1 this gives 1, 0, 3, 2.
- R7: `addr_out[AW-1:2]` changes only on a load. After four advances, `addr_out` returns to the loaded address.
- R8: A strobe takes priority over `adv` in the same cycle: the address is loaded and `beat` is 0.
- R9: `lin_mode` is sampled only on a load. A change of `lin_mode` during a burst does not alter the sequence.
- R10: A load is accepted on every consecutive cycle with no gap, and each loaded address appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | AW | External start address |
| start_cpu | input | 1 | Processor-side start strobe |
| start_ctl | input | 1 | Controller-side start strobe |
| adv | input | 1 | Advance to the next beat |
| lin_mode | input | 1 | Order select at load: 1 linear, 0 interleaved (tie low for the default) |
| addr_out | output | AW | Current burst address |
| beat | output | 2 | Beat index within the burst |

## Verification
The bench checks the wrap at the end of a burst. A design that carried the low-bit count into the upper bits would leave the aligned block, and one whose counter saturated would stick on the fourth beat. It sets both strobes together with advance: a design with the wrong priority would show beat 1 or a stepped address instead of the fresh load. It changes the mode pin in the middle of a burst: a design that reads the pin live would switch sequences part-way through. Back-to-back loads and a reset during a burst show whether a design drops a strobe or keeps stale state.

// File: rtl/bas_pkg.sv
// Package: shared types for the burst address sequence generator.
// Assumes: burst counter width fixed at two bits for four-beat bursts.
package bas_pkg;
    localparam int unsigned BEAT_W = 2;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } order_e;
endpackage

// File: rtl/bas_load_reg.sv
// Module: bas_load_reg
// Holds the start address and the counting order captured at each load.
// Assumes: load is the OR of all start strobes; reset is synchronous, active low.
module bas_load_reg
    import bas_pkg::*;
#(
    parameter int unsigned AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  order_e        order_in,
    output logic [AW-1:0] base_q,
    output order_e        order_q
);
    // Capture the address and order on load; clear to interleaved on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_INTERLEAVE;
        end else if (load) begin
            base_q  <= addr_in;
            order_q <= order_in;
        end
    end
endmodule

// File: rtl/bas_beat_ctr.sv
// Module: bas_beat_ctr
// Counts burst beats: clears on load, steps on advance, wraps naturally.
// Assumes: load has priority over advance.
module bas_beat_ctr #(
    parameter int unsigned BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    output logic [BW-1:0] beat_q
);
    // Beat register: reset and load clear it, advance increments modulo 2**BW.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= '0;
        end else if (adv) begin
            beat_q <= beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/bas_order_map.sv
// Module: bas_order_map
// Maps the start low bits and the beat index to the current low address bits.
// Assumes: purely combinational; the order is the value captured at load.
module bas_order_map
    import bas_pkg::*;
#(
    parameter int unsigned BW = 2
) (
    input  logic [BW-1:0] base_lo,
    input  logic [BW-1:0] beat,
    input  order_e        order,
    output logic [BW-1:0] lo_out
);
    logic [BW-1:0] lin_lo;
    logic [BW-1:0] ilv_lo;

    // Form both candidate sequences and select the captured one.
    always_comb begin
        lin_lo = base_lo + beat;
        ilv_lo = base_lo ^ beat;
        lo_out = (order == ORD_LINEAR) ? lin_lo : ilv_lo;
    end
endmodule

// File: rtl/bas_burst_gen.sv
// Module: bas_burst_gen (top)
// Generates a four-beat burst address sequence from a loaded start address.
// Either start strobe loads; advance steps the low bits in linear or
// interleaved order; the upper bits stay within the aligned block.
// Assumes: single rising-edge clock, synchronous active-low reset.
module bas_burst_gen
    import bas_pkg::*;
#(
    parameter int unsigned AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr_in,
    input  logic              start_cpu,
    input  logic              start_ctl,
    input  logic              adv,
    input  logic              lin_mode,
    output logic [AW-1:0]     addr_out,
    output logic [BEAT_W-1:0] beat
);
    localparam int unsigned BW = BEAT_W;
    localparam int unsigned UW = AW - BW;

    logic          load;
    order_e        order_in;
    order_e        order_q;
    logic [AW-1:0] base_q;
    logic [BW-1:0] beat_q;
    logic [BW-1:0] lo_bits;

    // Merge the strobes and decode the mode pin.
    always_comb begin
        load     = start_cpu | start_ctl;
        order_in = lin_mode ? ORD_LINEAR : ORD_INTERLEAVE;
    end

    bas_load_reg #(.AW(AW)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr_in  (addr_in),
        .order_in (order_in),
        .base_q   (base_q),
        .order_q  (order_q)
    );

    bas_beat_ctr #(.BW(BW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .adv    (adv),
        .beat_q (beat_q)
    );

    bas_order_map #(.BW(BW)) u_map (
        .base_lo (base_q[BW-1:0]),
        .beat    (beat_q),
        .order   (order_q),
        .lo_out  (lo_bits)
    );

    generate
        if (UW > 0) begin : g_upper
            // Join the fixed upper bits with the sequenced low bits.
            always_comb addr_out = {base_q[AW-1:BW], lo_bits};
        end else begin : g_low_only
            // Address is no wider than the beat field.
            always_comb addr_out = lo_bits[AW-1:0];
        end
    endgenerate

    // Beat index leaves the block unchanged.
    always_comb beat = beat_q;
endmodule

// File: rtl/bas_burst_gen_chk.sv
// Module: bas_burst_gen_chk
// Temporal checks on the ports of bas_burst_gen, attached by bind.
// Assumes: AW greater than the two-bit beat field.
module bas_burst_gen_chk #(
    parameter int unsigned AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_in,
    input logic          start_cpu,
    input logic          start_ctl,
    input logic          adv,
    input logic [AW-1:0] addr_out,
    input logic [1:0]    beat
);
    // R2, R8: any strobe loads the address and clears the beat.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cpu || start_ctl) |=> (addr_out == $past(addr_in)) && (beat == 2'd0));

    // R3: advance without strobe steps the beat modulo 4.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_cpu && !start_ctl && adv) |=> (beat == 2'($past(beat) + 2'd1)));

    // R4: idle cycle holds both outputs.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_cpu && !start_ctl && !adv) |=> ($stable(addr_out) && $stable(beat)));

    // R7: upper address bits stay put unless a load occurs.
    p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_cpu && !start_ctl) |=> $stable(addr_out[AW-1:2]));
endmodule

bind bas_burst_gen bas_burst_gen_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_in   (addr_in),
    .start_cpu (start_cpu),
    .start_ctl (start_ctl),
    .adv       (adv),
    .addr_out  (addr_out),
    .beat      (beat)
);

// File: tb/test_bas_burst_gen.sv
// Bench for bas_burst_gen: walks a vector table, then directed reset tests.
module test_bas_burst_gen;
    localparam int unsigned AW = 20;
    localparam int unsigned NV = 20;

    typedef struct packed {
        logic          cpu;
        logic          ctl;
        logic          adv;
        logic          lin;
        logic [AW-1:0] a;
        logic [AW-1:0] ea;
        logic [1:0]    eb;
        logic [7:0]    req;
    } vec_t;

    // Fields: cpu, ctl, adv, lin, addr_in, expected addr_out, expected beat, requirement.
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 20'h00ABE, 20'h00ABE, 2'd0, 8'd2},  // R2 load, linear
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h00ABF, 2'd1, 8'd5},  // R5 2->3
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h00ABC, 2'd2, 8'd7},  // R7 wrap to 0 in block
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h00ABD, 2'd3, 8'd5},  // R5 -> 1
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h00ABE, 2'd0, 8'd3},  // R3 beat wraps
        '{1'b0, 1'b0, 1'b0, 1'b1, 20'h00000, 20'h00ABE, 2'd0, 8'd4},  // R4 hold
        '{1'b0, 1'b1, 1'b0, 1'b0, 20'h12341, 20'h12341, 2'd0, 8'd2},  // R2 ctl load, interleaved
        '{1'b0, 1'b0, 1'b1, 1'b1, 20'h00000, 20'h12340, 2'd1, 8'd9},  // R9 mode change ignored
        '{1'b0, 1'b0, 1'b1, 1'b1, 20'h00000, 20'h12343, 2'd2, 8'd6},  // R6 1^2
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h12342, 2'd3, 8'd6},  // R6 1^3
        '{1'b1, 1'b1, 1'b1, 1'b1, 20'h55557, 20'h55557, 2'd0, 8'd8},  // R8 strobes beat advance
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h55554, 2'd1, 8'd5},  // R5 3+1 wraps in block
        '{1'b1, 1'b0, 1'b0, 1'b0, 20'h0FFF0, 20'h0FFF0, 2'd0, 8'd10}, // R10 back-to-back
        '{1'b0, 1'b1, 1'b0, 1'b1, 20'h0FFF1, 20'h0FFF1, 2'd0, 8'd10}, // R10
        '{1'b1, 1'b0, 1'b1, 1'b0, 20'h0FFF2, 20'h0FFF2, 2'd0, 8'd10}, // R10
        '{1'b0, 1'b0, 1'b0, 1'b1, 20'h0ABCD, 20'h0FFF2, 2'd0, 8'd4},  // R4 addr_in ignored
        '{1'b1, 1'b0, 1'b0, 1'b0, 20'h00002, 20'h00002, 2'd0, 8'd2},  // R2 interleaved base 2
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h00003, 2'd1, 8'd6},  // R6 2^1
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h00000, 2'd2, 8'd6},  // R6 2^2
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h00001, 2'd3, 8'd6}   // R6 2^3
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic          start_cpu;
    logic          start_ctl;
    logic          adv;
    logic          lin_mode;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat;

    int nvec  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    bas_burst_gen #(.AW(AW)) i_bas_burst_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_in   (addr_in),
        .start_cpu (start_cpu),
        .start_ctl (start_ctl),
        .adv       (adv),
        .lin_mode  (lin_mode),
        .addr_out  (addr_out),
        .beat      (beat)
    );

    task automatic check(input int rq, input logic [AW-1:0] ea, input logic [1:0] eb);
        nvec++;
        if (addr_out !== ea || beat !== eb) begin
            nfail++;
            $display("FAIL R%0d: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
                     rq, addr_out, beat, ea, eb);
        end
    endtask

    task automatic drive(input logic c, input logic t, input logic a, input logic l,
                         input logic [AW-1:0] ad);
        start_cpu = c;
        start_ctl = t;
        adv       = a;
        lin_mode  = l;
        addr_in   = ad;
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        drive(1'b0, 1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(1, 20'h00000, 2'd0); // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].cpu, TBL[i].ctl, TBL[i].adv, TBL[i].lin, TBL[i].a);
            @(posedge clk);
            @(negedge clk);
            check(int'(TBL[i].req), TBL[i].ea, TBL[i].eb);
        end

        // R1: reset in mid-burst clears address and beat despite adv.
        drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(1, 20'h00000, 2'd0);
        rst_n = 1'b1;

        // R1: order after reset is interleaved; load 1 with linear held off... order
        // comes from load, so load base 1 interleaved and step once: 1^1 = 0.
        drive(1'b1, 1'b0, 1'b0, 1'b0, 20'hFFFF1);
        @(posedge clk);
        @(negedge clk);
        check(2, 20'hFFFF1, 2'd0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
        @(posedge clk);
        @(negedge clk);
        check(6, 20'hFFFF0, 2'd1);

        // R7: four advances in linear order from base 1 return to the start.
        drive(1'b0, 1'b1, 1'b0, 1'b1, 20'h3FFFD);
        @(posedge clk);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, '0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(7, 20'h3FFFD, 2'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule